// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block drives a two-wire I2C bus as its only master. The host gives one-cycle command strobes: open the bus with a start condition, send a byte, receive a byte, or close the bus with a stop condition. The block builds each bus event from four equal phases whose length comes from a programmable divider. It drives SCL and SDA only through open-drain pull-low enables and reads both lines back. This read-back lets it honour clock stretching by a slave and notice when another device holds SDA low.

A transmitted byte goes out MSB first. The level the slave returns in the ninth clock is stored as a status bit. A received byte is shifted in MSB first, and the host picks the level the master drives in the ninth clock. Between bytes the master keeps SCL low and waits for the next command. When the host enables it, the master also stops after the eighth data bit with SCL held low. It raises the interrupt and goes on to the acknowledge clock only when the host clears the interrupt.

Top module: `i2c_byte_master`

## Requirements
- R1: A start strobe from the idle bus, or from the held bus, runs four phases. Both lines are released, then SDA is pulled low while SCL is released, then SCL is pulled low. When the sequence ends, irq_o is set and the bus is held with SCL pulled low and SDA released.
- R2: A stop strobe on the held bus runs four phases: both pulled low, then SCL released, then SDA released. It ends with both lines released, busy_o low and irq_o unchanged.
- R3: A write strobe sends tx_data_i MSB first. A bit value of 1 releases SDA and 0 pulls it low. SDA changes only in the first phase of a bit, while SCL is pulled low. The master releases SDA in the ninth clock and stores the sampled SDA level in ack_o (0 = acknowledged, 1 = not acknowledged).
- R4: A read strobe releases SDA for eight clocks and shifts the sampled levels into rx_data_o MSB first. In the ninth clock it pulls SDA low if ack_lvl_i was 0 at the strobe, and releases SDA if ack_lvl_i was 1.
- R5: The end of a byte's ninth clock sets irq_o. A pulse on irq_clr_i clears irq_o unless a setting event happens in the same cycle.
- R6: With wait_en_i high, the master stops after the eighth data bit with SCL pulled low and SDA released, and sets irq_o. It starts the ninth clock on the cycle after irq_clr_i is seen.
- R7: Each phase lasts div_i+1 clock cycles. Each bit has four phases: two with SCL pulled low, then two with SCL released. A byte therefore keeps busy_o high for 36*(div_i+1) cycles.
- R8: While the master releases SCL but scl_i reads low, the phase does not advance. Each such cycle makes the sequence one cycle longer.
- R9: If the master releases SDA for a transmitted data bit but samples it low at the end of the first SCL-high phase, it sets arb_lost_o and irq_o. It then releases both lines and returns to idle.
- R10: Strobes are ignored while a sequence runs. On the idle bus, only the start strobe has any effect.
- R11: After reset, both lines are released and irq_o, arb_lost_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| div_i | input | DIV_W | phase length minus one, in clock cycles |
| start_i | input | 1 | start condition command strobe |
| stop_i | input | 1 | stop condition command strobe |
| wr_i | input | 1 | transmit byte command strobe |
| rd_i | input | 1 | receive byte command strobe |
| tx_data_i | input | 8 | byte to transmit, taken at wr_i |
| ack_lvl_i | input | 1 | ninth-clock level for a received byte, taken at rd_i |
| wait_en_i | input | 1 | stop before the acknowledge clock |
| irq_clr_i | input | 1 | interrupt clear strobe |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | pull SCL low |
| sda_pull_o | output | 1 | pull SDA low |
| rx_data_o | output | 8 | byte observed on the bus, MSB first |
| ack_o | output | 1 | acknowledge level sampled after a transmitted byte |
| irq_o | output | 1 | interrupt flag |
| arb_lost_o | output | 1 | SDA lost while released, cleared by the next start |
| busy_o | output | 1 | a start, byte or stop sequence is running |

## Verification
The bench keeps DIV_W at its default of 8 and drives div_i with 2 for most sequences. This gives each phase three cycles, so any off-by-one in a phase shows up as a compared sample. One byte runs with div_i at 0, where every phase is a single cycle and the tick must fire on every edge. A slave model acknowledges, returns read data, stretches one clock by five cycles and grabs SDA in the middle of a byte. These actions bring the stall path and the arbitration exit within reach.

// File: rtl/i2c_master_pkg.sv
package i2c_master_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_WAIT, ST_STOP
  } mst_state_e;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stall_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q >= div_i);
  assign tick_o = run_i && !stall_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (stall_i)     cnt_q <= cnt_q;
    else if (at_end)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)) else $error("timer not cleared"); // R7
endmodule

// File: rtl/i2c_shift_reg.sv
module i2c_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign q_o   = sr_q;
  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_master_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       tx_data_i,
  input  logic             ack_lvl_i,
  input  logic             wait_en_i,
  input  logic             irq_clr_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic [7:0]       rx_data_o,
  output logic             ack_o,
  output logic             irq_o,
  output logic             arb_lost_o,
  output logic             busy_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(BYTE_BITS - 1);
  localparam logic [IDX_W-1:0] ACK_IDX   = IDX_W'(BYTE_BITS);

  mst_state_e       st_q;
  logic [1:0]       ph_q;
  logic [IDX_W-1:0] idx_q;
  logic             rx_q, ackl_q, from_hold_q, smp_q, ack_q, irq_q, arb_q;
  logic             run, stall, tick, data_bit, sr_msb, arb_cond, irq_set;
  logic             load_tx, shift_en;

  assign run      = (st_q == ST_START) || (st_q == ST_BIT) || (st_q == ST_STOP);
  assign stall    = !scl_pull_o && !scl_i;
  assign data_bit = (idx_q < ACK_IDX);
  assign arb_cond = data_bit && !rx_q && sr_msb && !sda_i;
  assign load_tx  = (st_q == ST_HOLD) && !start_i && !stop_i && wr_i;
  assign shift_en = tick && (st_q == ST_BIT) && (ph_q == 2'd3) && data_bit;

  i2c_phase_timer #(.DIV_W(DIV_W)) i_timer (
    .clk_i, .rst_ni, .run_i(run), .stall_i(stall), .div_i, .tick_o(tick)
  );

  i2c_shift_reg #(.W(BYTE_BITS)) i_shift (
    .clk_i, .rst_ni, .load_i(load_tx), .data_i(tx_data_i),
    .shift_i(shift_en), .bit_i(smp_q), .q_o(rx_data_o), .msb_o(sr_msb)
  );

  always_comb begin
    irq_set = 1'b0;
    if (tick) begin
      if (st_q == ST_START && ph_q == 2'd3) irq_set = 1'b1;
      if (st_q == ST_BIT && ph_q == 2'd2 && arb_cond) irq_set = 1'b1;
      if (st_q == ST_BIT && ph_q == 2'd3 &&
          (!data_bit || (idx_q == LAST_DATA && wait_en_i))) irq_set = 1'b1;
    end
  end

  always_comb begin
    scl_pull_o = 1'b0;
    sda_pull_o = 1'b0;
    unique case (st_q)
      ST_HOLD, ST_WAIT: scl_pull_o = 1'b1;
      ST_START: begin
        scl_pull_o = (ph_q == 2'd3) || (ph_q == 2'd0 && from_hold_q);
        sda_pull_o = ph_q[1];
      end
      ST_STOP: begin
        scl_pull_o = (ph_q == 2'd0);
        sda_pull_o = !ph_q[1];
      end
      ST_BIT: begin
        scl_pull_o = !ph_q[1];
        if (data_bit) sda_pull_o = !rx_q && !sr_msb;
        else          sda_pull_o = rx_q && !ackl_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= '0; idx_q <= '0;
      rx_q <= 1'b0; ackl_q <= 1'b0; from_hold_q <= 1'b0; smp_q <= 1'b0;
      ack_q <= 1'b0; irq_q <= 1'b0; arb_q <= 1'b0;
    end else begin
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_START; ph_q <= '0; from_hold_q <= 1'b0; arb_q <= 1'b0;
        end
        ST_HOLD: begin
          if (start_i) begin
            st_q <= ST_START; ph_q <= '0; from_hold_q <= 1'b1; arb_q <= 1'b0;
          end else if (stop_i) begin
            st_q <= ST_STOP; ph_q <= '0;
          end else if (wr_i || rd_i) begin
            st_q <= ST_BIT; ph_q <= '0; idx_q <= '0;
            rx_q <= !wr_i; ackl_q <= ack_lvl_i;
          end
        end
        ST_WAIT: if (irq_clr_i) begin
          st_q <= ST_BIT; ph_q <= '0;
        end
        ST_START: if (tick) begin
          if (ph_q == 2'd3) st_q <= ST_HOLD;
          else              ph_q <= ph_q + 2'd1;
        end
        ST_STOP: if (tick) begin
          if (ph_q == 2'd3) st_q <= ST_IDLE;
          else              ph_q <= ph_q + 2'd1;
        end
        ST_BIT: if (tick) begin
          if (ph_q == 2'd2) begin
            smp_q <= sda_i;
            if (arb_cond) begin
              st_q <= ST_IDLE; arb_q <= 1'b1;
            end else if (!data_bit && !rx_q) begin
              ack_q <= sda_i;
            end
            ph_q <= 2'd3;
          end else if (ph_q == 2'd3) begin
            ph_q <= '0;
            if (data_bit) begin
              idx_q <= idx_q + 1'b1;
              if (idx_q == LAST_DATA && wait_en_i) st_q <= ST_WAIT;
            end else begin
              st_q <= ST_HOLD;
            end
          end else begin
            ph_q <= ph_q + 2'd1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o      = ack_q;
  assign irq_o      = irq_q;
  assign arb_lost_o = arb_q;
  assign busy_o     = run;

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT && $past(st_q == ST_BIT) && !scl_pull_o && $past(!scl_pull_o))
      |-> $stable(sda_pull_o)) else $error("sda moved with scl high"); // R3
  AST_STALL_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !scl_pull_o && !scl_i) |=> ($stable(ph_q) && $stable(st_q)))
    else $error("phase advanced while stretched"); // R8
  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q == ST_WAIT) && st_q != ST_WAIT) |-> $past(irq_clr_i))
    else $error("wait left without clear"); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !tick) |=> !irq_o) else $error("irq not cleared"); // R5
  AST_ARB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_lost_o) |-> (!scl_pull_o && !sda_pull_o))
    else $error("lines held after arbitration loss"); // R9
  AST_IDLE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE))
    else $error("idle left without start"); // R10
endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 0, stop = 0, wr = 0, rd = 0, ack_lvl = 0, wait_en = 0, irq_clr = 0;
  logic [7:0] tx_data = '0;
  int div_v = 2;
  logic [7:0] div;
  logic scl_i, sda_i, scl_pull, sda_pull, ack, irq, arb_lost, busy;
  logic [7:0] rx_data;
  logic scl_hold = 0, slv_pull = 0;

  assign div   = div_v[7:0];
  assign scl_i = !(scl_pull || scl_hold);
  assign sda_i = !(sda_pull || slv_pull);

  i2c_byte_master #(.DIV_W(8)) i_i2c_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .start_i(start), .stop_i(stop),
    .wr_i(wr), .rd_i(rd), .tx_data_i(tx_data), .ack_lvl_i(ack_lvl),
    .wait_en_i(wait_en), .irq_clr_i(irq_clr), .scl_i(scl_i), .sda_i(sda_i),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .rx_data_o(rx_data),
    .ack_o(ack), .irq_o(irq), .arb_lost_o(arb_lost), .busy_o(busy)
  );

  typedef struct packed { logic scl; logic sda; logic slv; } ent_t;
  ent_t q[$];
  logic rest_scl = 0, rest_sda = 0;
  int checks = 0, fails = 0, cycles = 0, busy_cnt = 0, stretch_left = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // reference model: one queue entry per unstalled cycle
  initial forever begin
    @(posedge clk); #2;
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R7 watchdog act=running exp=finished");
      summary();
    end
    if (busy) busy_cnt++;
    if (rst_n) begin
      if (q.size() > 0) begin
        ent_t e;
        logic hold_n;
        e = q[0];
        hold_n = !e.scl && (stretch_left > 0);
        if (hold_n) stretch_left--;
        scl_hold = hold_n;
        slv_pull = e.slv;
        chk("R3 scl line", {31'd0, scl_pull}, {31'd0, e.scl});
        chk("R3 sda line", {31'd0, sda_pull}, {31'd0, e.sda});
        if (!(hold_n && !scl_pull)) void'(q.pop_front());
      end else begin
        scl_hold = 0;
        slv_pull = 0;
        chk("R10 scl rest", {31'd0, scl_pull}, {31'd0, rest_scl});
        chk("R10 sda rest", {31'd0, sda_pull}, {31'd0, rest_sda});
      end
    end
  end

  task automatic push_ph(logic s, logic d, logic l);
    for (int i = 0; i <= div_v; i++) q.push_back('{scl: s, sda: d, slv: l});
  endtask

  task automatic push_bit(logic d, logic l);
    push_ph(1, d, l); push_ph(1, d, l); push_ph(0, d, l); push_ph(0, d, l);
  endtask

  task automatic do_start(logic from_hold);
    @(negedge clk);
    start = 1;
    push_ph(from_hold, 0, 0); push_ph(0, 0, 0); push_ph(0, 1, 0); push_ph(1, 1, 0);
    rest_scl = 1; rest_sda = 0;
    @(negedge clk); start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop = 1;
    push_ph(1, 1, 0); push_ph(0, 1, 0); push_ph(0, 0, 0); push_ph(0, 0, 0);
    rest_scl = 0; rest_sda = 0;
    @(negedge clk); stop = 0;
  endtask

  task automatic do_wr(logic [7:0] b, logic nack, int arb_bit);
    @(negedge clk);
    busy_cnt = 0;
    wr = 1; tx_data = b;
    rest_scl = 1; rest_sda = 0;
    for (int i = 0; i < 8; i++) begin
      if (i == arb_bit) begin
        push_ph(1, !b[7-i], 1); push_ph(1, !b[7-i], 1); push_ph(0, !b[7-i], 1);
        rest_scl = 0; rest_sda = 0;
        break;
      end
      push_bit(!b[7-i], 0);
    end
    if (arb_bit < 0 && !wait_en) push_bit(0, !nack);
    @(negedge clk); wr = 0;
  endtask

  task automatic do_rd(logic [7:0] b, logic lvl);
    @(negedge clk);
    busy_cnt = 0;
    rd = 1; ack_lvl = lvl;
    for (int i = 0; i < 8; i++) push_bit(0, !b[7-i]);
    push_bit(!lvl, 0);
    rest_scl = 1; rest_sda = 0;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_done();
    do begin @(posedge clk); #3; end while (q.size() != 0 || busy);
  endtask

  task automatic clr_irq(string tag);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(tag, {31'd0, irq}, 32'd0);
  endtask

  task automatic pulse_raw(int which);
    @(negedge clk);
    case (which) 0: start = 1; 1: stop = 1; 2: wr = 1; default: rd = 1; endcase
    @(negedge clk);
    start = 0; stop = 0; wr = 0; rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 scl", {31'd0, scl_pull}, 0);
    chk("R11 sda", {31'd0, sda_pull}, 0);
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 arb", {31'd0, arb_lost}, 0);
    chk("R11 busy", {31'd0, busy}, 0);
    // R10: stop, write and read on the idle bus do nothing
    pulse_raw(1); pulse_raw(2); pulse_raw(3);
    repeat (6) @(negedge clk);
    chk("R10 idle busy", {31'd0, busy}, 0);
    chk("R10 idle irq", {31'd0, irq}, 0);
    // R1 start from idle
    do_start(0); wait_done();
    chk("R1 start irq", {31'd0, irq}, 1);
    clr_irq("R5 clear after start");
    // R3 write acked, with an ignored start during the byte (R10)
    do_wr(8'hA5, 0, -1);
    repeat (5) @(negedge clk);
    pulse_raw(0);
    wait_done();
    chk("R7 byte length div2", busy_cnt, 108);
    chk("R5 byte end irq", {31'd0, irq}, 1);
    chk("R3 ack status", {31'd0, ack}, 0);
    clr_irq("R5 clear after write");
    do_wr(8'h3C, 1, -1); wait_done();
    chk("R3 nack status", {31'd0, ack}, 1);
    clr_irq("R5 clear nack");
    // R4 reads
    do_rd(8'h5A, 0); wait_done();
    chk("R4 rx data 5A", {24'd0, rx_data}, 32'h5A);
    chk("R4 irq", {31'd0, irq}, 1);
    clr_irq("R5 clear read");
    do_rd(8'hC3, 1); wait_done();
    chk("R4 rx data C3", {24'd0, rx_data}, 32'hC3);
    clr_irq("R5 clear read2");
    // R6 wait before acknowledge clock
    wait_en = 1;
    do_wr(8'h96, 0, -1); wait_done();
    chk("R6 wait irq", {31'd0, irq}, 1);
    repeat (10) @(negedge clk);
    chk("R6 wait scl held", {31'd0, scl_pull}, 1);
    chk("R6 wait busy", {31'd0, busy}, 0);
    @(negedge clk);
    irq_clr = 1;
    push_bit(0, 1);
    @(negedge clk); irq_clr = 0;
    wait_done();
    chk("R6 ack after wait", {31'd0, ack}, 0);
    chk("R6 irq after ack", {31'd0, irq}, 1);
    clr_irq("R5 clear wait byte");
    wait_en = 0;
    // R8 clock stretch by five cycles
    stretch_left = 5;
    do_wr(8'h81, 0, -1); wait_done();
    chk("R8 stretched length", busy_cnt, 113);
    chk("R8 ack", {31'd0, ack}, 0);
    clr_irq("R5 clear stretch");
    // R7 single-cycle phases
    div_v = 0;
    do_wr(8'h5F, 0, -1); wait_done();
    chk("R7 byte length div0", busy_cnt, 36);
    clr_irq("R5 clear div0");
    div_v = 2;
    // R1 repeated start
    do_start(1); wait_done();
    chk("R1 repeated start irq", {31'd0, irq}, 1);
    clr_irq("R5 clear rstart");
    // R2 stop
    do_stop(); wait_done();
    chk("R2 stop busy", {31'd0, busy}, 0);
    chk("R2 stop irq unchanged", {31'd0, irq}, 0);
    chk("R2 lines released", {30'd0, scl_pull, sda_pull}, 0);
    // R9 arbitration loss on bit index 2
    do_start(0); wait_done();
    clr_irq("R5 clear before arb");
    do_wr(8'hFF, 0, 2); wait_done();
    chk("R9 arb flag", {31'd0, arb_lost}, 1);
    chk("R9 arb irq", {31'd0, irq}, 1);
    chk("R9 released", {30'd0, scl_pull, sda_pull}, 0);
    repeat (6) @(negedge clk);
    chk("R9 stays idle", {31'd0, busy}, 0);
    summary();
  end
endmodule